// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block merges a wide set of level-sensitive interrupt sources into a small number of group lines. Sources are gathered eight at a time into groups. Each group has its own eight-bit enable mask. A group line is asserted while any source in that group is both high and enabled. Source `n` lands in group `n/8`, at bit `n mod 8` of that group. With the default parameters there are 64 groups and 512 sources.

Software reaches the block over a simple single-cycle register bus. Each bank of four consecutive groups owns four 32-bit words:

- an enable-set word, where written ones are ORed into the mask;
- an enable-clear word, where written ones clear mask bits;
- a raw status word, which reads the pending bits before masking;
- a masked status word, which reads mask AND pending.

Two summary words follow the banks and hold one bit per asserted group. A mode input selects a reduced configuration with 16 groups and a trimmed address map. Accesses outside the allowed map are flagged on an error pulse and change nothing.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset, every mask bit, every pending bit, every group line, the read data and the error flag are zero.
- R2: Source `n` drives pending bit `n mod 8` of group `n/8`. That bit follows the input level one clock later and does not latch: a pulse that has ended leaves no trace.
- R3: Group line `g` is high exactly when mask byte `g` AND pending byte `g` is non-zero. It is registered and changes one clock after the input or mask change that causes it.
- R4: Byte address `bank*16 + 0x0` is enable-set for groups `bank*4` to `bank*4+3`. Group `bank*4+k` uses write data bits `[8k+7:8k]`. Ones are ORed into the mask and zeros leave it unchanged.
- R5: Byte address `bank*16 + 0x4` is enable-clear. Each written one clears that mask bit and each zero leaves it unchanged.
- R6: Byte address `bank*16 + 0x8` reads the raw pending bytes and `bank*16 + 0xC` reads mask AND pending. Both use the same byte packing as R4.
- R7: Byte address 0x100 reads one bit per group for groups 0–31, and 0x104 does the same for groups 32–63. Bit `g mod 32` is 1 while group line `g` is high.
- R8: Read data and the error flag appear in the cycle after the request, for one cycle only. Reads of the enable-set and enable-clear words return zero. Address bits [1:0] are ignored.
- R9: These accesses are illegal: a write to a raw status, masked status or summary word; any write at 0x100 or above; any access at 0x108 or above. An illegal access raises the error flag, returns zero data and changes no mask bit.
- R10: While the mode input is high, only byte addresses 0x000–0x03C and 0x100 are legal. Every other access is illegal as in R9.
- R11: While the mode input is high, sources of group 16 and above are ignored: their pending bits read zero and their group lines stay low. Their masks are kept, so the lines return once the mode input drops.
- R12: When a mask write and a source change reach the same group in the same cycle, the group line in the next cycle reflects both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode | input | 1 | Selects the reduced 16-group configuration |
| src_i | input | 512 | Level interrupt sources |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Illegal-access pulse, one cycle after the request |
| grp_irq | output | 64 | One level line per group |

## Verification
Every result appears exactly one clock after its cause:

- group lines after a source edge, a mask write or a mode change;
- read data and the error flag after a request.

The bench drives stimulus on the falling edge. It samples on the following falling edge, which is half a period after the single register stage has captured the change. Each bus task holds its request for exactly one rising edge and reads the result back at that sample point. Once a single-pulse check has seen the flag, the idle cycle that follows it is checked for a cleared error flag. For the same-cycle case, the source edge and the enable write are launched on one falling edge, and the group line is checked on the next.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

    localparam int SRC_PER_GRP  = 8;
    localparam int GRP_PER_WORD = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SET,
        SEL_CLR,
        SEL_RAW,
        SEL_MSK,
        SEL_SUM
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_PER_GRP-1:0] mask;
        logic [SRC_PER_GRP-1:0] pend;
        logic                   irq;
    } grp_state_t;

    typedef struct packed {
        logic [31:0] rdata;
        logic        err;
    } bus_state_t;

endpackage

// File: rtl/cmb_decode.sv
module cmb_decode
    import cmb_pkg::*;
#(
    parameter int NUM_GROUPS = 64,
    parameter int EXT_GROUPS = 16,
    parameter int ADDR_W     = 9,
    parameter int BANK_W     = 4,
    parameter int SUM_W      = 1
) (
    input  logic              ext_mode,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [BANK_W-1:0] bank,
    output logic [SUM_W-1:0]  sum_idx,
    output logic              legal
);

    localparam int WORD_W    = ADDR_W - 2;
    localparam int SUM_WORDS = NUM_GROUPS / 32;

    localparam logic [WORD_W-1:0] BANK_WORDS = WORD_W'(NUM_GROUPS);
    localparam logic [WORD_W-1:0] MAP_END    = WORD_W'(NUM_GROUPS + SUM_WORDS);
    localparam logic [WORD_W-1:0] EXT_WORDS  = WORD_W'(EXT_GROUPS);

    logic [WORD_W-1:0] word;
    logic              is_bank;
    logic              is_sum;
    logic              ext_ok;
    logic [WORD_W-1:0] sum_off;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        is_bank = (word < BANK_WORDS);
        is_sum  = (word >= BANK_WORDS) && (word < MAP_END);
        ext_ok  = (word < EXT_WORDS) || (word == BANK_WORDS);
        sum_off = word - BANK_WORDS;
        sum_idx = sum_off[SUM_W-1:0];
        bank    = word[BANK_W+1:2];

        sel = SEL_NONE;
        if (is_bank) begin
            case (word[1:0])
                2'd0:    sel = SEL_SET;
                2'd1:    sel = SEL_CLR;
                2'd2:    sel = SEL_RAW;
                default: sel = SEL_MSK;
            endcase
        end else if (is_sum) begin
            sel = SEL_SUM;
        end

        if (write) begin
            legal = is_bank && !word[1];
        end else begin
            legal = is_bank || is_sum;
        end
        if (ext_mode && !ext_ok) begin
            legal = 1'b0;
        end
    end

endmodule

// File: rtl/cmb_group.sv
module cmb_group
    import cmb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept_src,
    input  logic [SRC_PER_GRP-1:0] src,
    input  logic                   set_we,
    input  logic                   clr_we,
    input  logic [SRC_PER_GRP-1:0] wbyte,
    output logic [SRC_PER_GRP-1:0] mask_o,
    output logic [SRC_PER_GRP-1:0] pend_o,
    output logic                   irq_o
);

    grp_state_t st_d;
    grp_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) begin
            st_d.mask = st_d.mask | wbyte;
        end
        if (clr_we) begin
            st_d.mask = st_d.mask & ~wbyte;
        end
        st_d.pend = accept_src ? src : '0;
        st_d.irq  = |(st_d.mask & st_d.pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;

    AST_OUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(mask_o & pend_o)); // R3

    AST_PEND_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept_src |=> pend_o == $past(src)); // R2

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> (mask_o & $past(wbyte)) == $past(wbyte)); // R4

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (mask_o & $past(wbyte)) == '0); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask_o)); // R9

    AST_IGNORE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_src |=> pend_o == '0); // R11

endmodule

// File: rtl/cmb_readmux.sv
module cmb_readmux
    import cmb_pkg::*;
#(
    parameter int NUM_GROUPS = 64,
    parameter int BANK_W     = 4,
    parameter int SUM_W      = 1
) (
    input  reg_sel_e                                 sel,
    input  logic [BANK_W-1:0]                        bank,
    input  logic [SUM_W-1:0]                         sum_idx,
    input  logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0]   mask_all,
    input  logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0]   pend_all,
    input  logic [NUM_GROUPS-1:0]                    irq_all,
    output logic [31:0]                              rd_word
);

    localparam int SUM_WORDS = NUM_GROUPS / 32;

    logic [31:0] raw_word;
    logic [31:0] msk_word;
    logic [31:0] sum_word;

    always_comb begin
        raw_word = '0;
        msk_word = '0;
        for (int k = 0; k < GRP_PER_WORD; k++) begin
            raw_word[8*k +: 8] = pend_all[int'(bank)*GRP_PER_WORD + k];
            msk_word[8*k +: 8] = pend_all[int'(bank)*GRP_PER_WORD + k]
                               & mask_all[int'(bank)*GRP_PER_WORD + k];
        end
        sum_word = '0;
        for (int w = 0; w < SUM_WORDS; w++) begin
            if (int'(sum_idx) == w) begin
                sum_word = irq_all[32*w +: 32];
            end
        end
        case (sel)
            SEL_RAW: rd_word = raw_word;
            SEL_MSK: rd_word = msk_word;
            SEL_SUM: rd_word = sum_word;
            default: rd_word = '0;
        endcase
    end

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import cmb_pkg::*;
#(
    parameter int NUM_GROUPS = 64,
    parameter int EXT_GROUPS = 16,
    parameter int ADDR_W     = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ext_mode,
    input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] src_i,
    input  logic                              bus_valid,
    input  logic                              bus_write,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    output logic                              bus_err,
    output logic [NUM_GROUPS-1:0]             grp_irq
);

    localparam int NUM_BANKS = NUM_GROUPS / GRP_PER_WORD;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int SUM_WORDS = NUM_GROUPS / 32;
    localparam int SUM_W     = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1;

    reg_sel_e          sel;
    logic [BANK_W-1:0] bank;
    logic [SUM_W-1:0]  sum_idx;
    logic              legal;
    logic              wr_go;
    logic [31:0]       rd_word;

    logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0] mask_all;
    logic [NUM_GROUPS-1:0][SRC_PER_GRP-1:0] pend_all;
    logic [NUM_GROUPS-1:0]                  irq_all;

    bus_state_t bus_d;
    bus_state_t bus_q;

    cmb_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .EXT_GROUPS (EXT_GROUPS),
        .ADDR_W     (ADDR_W),
        .BANK_W     (BANK_W),
        .SUM_W      (SUM_W)
    ) u_decode (
        .ext_mode (ext_mode),
        .write    (bus_write),
        .addr     (bus_addr),
        .sel      (sel),
        .bank     (bank),
        .sum_idx  (sum_idx),
        .legal    (legal)
    );

    assign wr_go = bus_valid && bus_write && legal;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int BANK_OF = g / GRP_PER_WORD;
        localparam int LANE    = g % GRP_PER_WORD;

        logic hit;
        assign hit = wr_go && (bank == BANK_W'(BANK_OF));

        cmb_group u_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .accept_src (!ext_mode || (g < EXT_GROUPS)),
            .src        (src_i[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .set_we     (hit && (sel == SEL_SET)),
            .clr_we     (hit && (sel == SEL_CLR)),
            .wbyte      (bus_wdata[LANE*8 +: 8]),
            .mask_o     (mask_all[g]),
            .pend_o     (pend_all[g]),
            .irq_o      (irq_all[g])
        );
    end

    cmb_readmux #(
        .NUM_GROUPS (NUM_GROUPS),
        .BANK_W     (BANK_W),
        .SUM_W      (SUM_W)
    ) u_readmux (
        .sel      (sel),
        .bank     (bank),
        .sum_idx  (sum_idx),
        .mask_all (mask_all),
        .pend_all (pend_all),
        .irq_all  (irq_all),
        .rd_word  (rd_word)
    );

    always_comb begin
        bus_d       = '0;
        bus_d.err   = bus_valid && !legal;
        bus_d.rdata = (bus_valid && !bus_write && legal) ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign bus_rdata = bus_q.rdata;
    assign bus_err   = bus_q.err;
    assign grp_irq   = irq_all;

    AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_valid)); // R8

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == '0); // R9

    AST_ILLEGAL_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !legal) |=> $stable(mask_all)); // R9

    AST_EXT_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> grp_irq[NUM_GROUPS-1:EXT_GROUPS] == '0); // R11

endmodule

// File: tb/sim_irq_group_combiner.sv
`timescale 1ns/1ps
module sim_irq_group_combiner;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ext_mode = 1'b0;
    logic [511:0] src = '0;
    logic         valid = 1'b0;
    logic         wr = 1'b0;
    logic [8:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         err;
    logic [63:0]  grp_irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_group_combiner u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .src_i     (src),
        .bus_valid (valid),
        .bus_write (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .bus_err   (err),
        .grp_irq   (grp_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        valid = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        d = rdata; e = err;
        valid = 1'b0;
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] v, output logic e);
        @(negedge clk);
        valid = 1'b1; wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        e = err;
        valid = 1'b0; wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic e;
        chk("R1 lines", grp_irq, 64'h0);
        chk("R1 rdata", rdata, 0);
        chk("R1 err", err, 0);
        bus_rd(9'h018, d, e);
        chk("R1 raw zero", d, 0);
    endtask

    task automatic t_pending;
        logic [31:0] d; logic e;
        @(negedge clk); src[43] = 1'b1;
        @(negedge clk);
        chk("R3 masked off", grp_irq, 64'h0);
        bus_rd(9'h018, d, e);
        chk("R2 raw group5 bit3", d, 32'h0000_0800);
        chk("R6 masked zero", {31'h0, e}, 0);
        bus_rd(9'h01C, d, e);
        chk("R6 masked read", d, 0);
    endtask

    task automatic t_enable;
        logic [31:0] d; logic e;
        bus_wr(9'h010, 32'h0000_0800, e);
        chk("R4 set legal", e, 0);
        chk("R3 line up", grp_irq, 64'h20);
        bus_rd(9'h01C, d, e);
        chk("R6 masked", d, 32'h0000_0800);
        bus_rd(9'h010, d, e);
        chk("R8 set word reads zero", d, 0);
        @(negedge clk); src[43] = 1'b0;
        @(negedge clk);
        chk("R2 no latch line", grp_irq, 64'h0);
        bus_rd(9'h018, d, e);
        chk("R2 no latch raw", d, 0);
    endtask

    task automatic t_clear_or;
        logic [31:0] d; logic e;
        @(negedge clk); src[43] = 1'b1;
        @(negedge clk);
        chk("R3 line back", grp_irq[5], 1);
        bus_wr(9'h014, 32'h0000_0100, e);
        chk("R5 zeros keep", grp_irq[5], 1);
        bus_wr(9'h014, 32'h0000_0800, e);
        chk("R5 clear", grp_irq[5], 0);
        bus_wr(9'h010, 32'h0000_0800, e);
        bus_wr(9'h010, 32'h0000_0400, e);
        @(negedge clk); src[42] = 1'b1;
        @(negedge clk);
        bus_rd(9'h01C, d, e);
        chk("R4 OR keeps bits", d, 32'h0000_0C00);
    endtask

    task automatic t_summary;
        logic [31:0] d; logic e;
        bus_wr(9'h0A0, 32'h0000_0080, e);
        @(negedge clk); src[327] = 1'b1;
        @(negedge clk);
        chk("R3 group40", grp_irq[40], 1);
        bus_rd(9'h100, d, e);
        chk("R7 summary low", d, 32'h0000_0020);
        bus_rd(9'h104, d, e);
        chk("R7 summary high", d, 32'h0000_0100);
        chk("R7 err", e, 0);
    endtask

    task automatic t_illegal;
        logic [31:0] d; logic e;
        bus_wr(9'h018, 32'hFFFF_FFFF, e);
        chk("R9 raw write err", e, 1);
        chk("R9 err data zero", rdata, 0);
        @(negedge clk);
        chk("R8 err single pulse", err, 0);
        bus_rd(9'h01C, d, e);
        chk("R9 mask unchanged", d, 32'h0000_0C00);
        bus_wr(9'h01C, 32'hFFFF_FFFF, e);
        chk("R9 masked write err", e, 1);
        bus_wr(9'h100, 32'h1, e);
        chk("R9 summary write err", e, 1);
        bus_rd(9'h108, d, e);
        chk("R9 read beyond map", e, 1);
        chk("R9 read beyond data", d, 0);
        bus_wr(9'h1FC, 32'h1, e);
        chk("R9 write high err", e, 1);
    endtask

    task automatic t_ext;
        logic [31:0] d; logic e;
        @(negedge clk); ext_mode = 1'b1;
        @(negedge clk);
        chk("R11 upper line dropped", grp_irq[40], 0);
        chk("R11 lower line kept", grp_irq[5], 1);
        bus_rd(9'h03C, d, e);
        chk("R10 0x3C legal", e, 0);
        bus_rd(9'h040, d, e);
        chk("R10 0x40 illegal", e, 1);
        bus_rd(9'h104, d, e);
        chk("R10 0x104 illegal", e, 1);
        bus_rd(9'h100, d, e);
        chk("R10 0x100 legal", e, 0);
        chk("R11 summary", d, 32'h0000_0020);
        bus_wr(9'h0A4, 32'h0000_0080, e);
        chk("R10 clear write illegal", e, 1);
        @(negedge clk); ext_mode = 1'b0;
        @(negedge clk);
        chk("R11 mask kept", grp_irq[40], 1);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        src[56] = 1'b1;
        valid = 1'b1; wr = 1'b1; addr = 9'h010; wdata = 32'h0100_0000;
        @(negedge clk);
        valid = 1'b0; wr = 1'b0;
        chk("R12 both applied", grp_irq[7], 1);
        @(negedge clk);
        src[56] = 1'b0;
        valid = 1'b1; wr = 1'b1; addr = 9'h014; wdata = 32'h0100_0000;
        @(negedge clk);
        valid = 1'b0; wr = 1'b0;
        chk("R12 both removed", grp_irq[7], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_enable();
        t_clear_or();
        t_summary();
        t_illegal();
        t_ext();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule